// File: doc/BRIEF.md
# Framed serial DAC input receiver

This block is the digital front end of a serial-input voltage DAC. A host writes to it over three wires: an active-low frame select, a serial clock and a serial data line. All three are brought into the system clock domain through multi-flop synchronizers, and their edges are detected there. A frame starts when the select line falls. Bits are taken on each falling edge of the serial clock, most significant bit first.

A frame carries 24 bits. The first six are ignored. The next two choose the power mode, and the last sixteen are the converter code. When the 24th bit arrives, the mode register is loaded. The code register is loaded only if the new mode is normal operation; a power-down frame keeps the code already held. A one-cycle update strobe marks every commit. If the select line rises before the 24th bit, the frame is dropped, both registers keep their values, and a one-cycle abort flag is raised. The analog string, the output amplifier and the power-down load network are outside this block. The mode is only reported as a code for them to use.

Top module: `sdac_frame_rx`

## Requirements
- R1: While reset is high, and after it is released, `dac_code` is 0, `pd_mode` is 0, and `update` and `abort` are low until a frame ends.
- R2: A frame is the span from a falling edge of `sync_n` to its next rising edge. When the 24th falling edge of `sclk` arrives inside a frame, `dac_code` takes frame bits 16..1 counted from the end, that is the last 16 bits sent, first-sent bit as the MSB.
- R3: The first six bits of a frame have no effect on `dac_code` or `pd_mode`.
- R4: Frame bits 7 and 8 (counted from the start; bit 7 is the MSB) load `pd_mode` on the 24th falling edge. The codes are 00 normal, 01 power-down with a 1 kΩ load, 10 power-down with a 100 kΩ load, and 11 power-down with high-impedance output.
- R5: Each completed frame raises `update` for exactly one system clock cycle.
- R6: If `sync_n` rises before the 24th falling edge, `dac_code` and `pd_mode` are unchanged, `update` stays low, and `abort` is high for exactly one cycle.
- R7: Further falling `sclk` edges after the 24th, while `sync_n` stays low, are ignored: there is no second update and no register change. A rise of `sync_n` after a completed frame raises no abort.
- R8: A frame that selects any power-down mode (nonzero mode bits) leaves `dac_code` unchanged. A later normal-mode frame loads its code.
- R9: After an aborted frame, the next frame starts from an empty shift register and decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low frame select, asynchronous |
| sclk | input | 1 | Serial clock, data taken on falling edges, asynchronous |
| sdin | input | 1 | Serial data, MSB first, asynchronous |
| dac_code | output | 16 | Committed converter code |
| pd_mode | output | 2 | Committed power mode code |
| update | output | 1 | One-cycle pulse on each commit |
| abort | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The bench uses the default parameters: a 24-bit frame, a 16-bit code, a 2-bit mode and two synchronizer stages. It drives the serial clock with a half period of four system clocks. That ratio gives enough margin to reach every path in the frame logic: aborts at a mid-frame bit, frames that run well past 24 edges, all four mode codes, and a restart after an abort. Because the frame width and the code width are parameters, the frame fields sit where the behaviour needs them.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL   = 2'b00,
    PM_PD_1K    = 2'b01,
    PM_PD_100K  = 2'b10,
    PM_PD_HIZ   = 2'b11
  } pwr_mode_t;

  localparam int unsigned MODE_W = 2;
endpackage

// File: rtl/sdac_in_sync.sv
module sdac_in_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/sdac_shift_ctrl.sv
module sdac_shift_ctrl #(
  parameter int unsigned FRAME_BITS = 24,
  parameter int unsigned PAYLOAD_W  = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sync_lvl,
  input  logic                 sclk_lvl,
  input  logic                 din_lvl,
  output logic                 commit,
  output logic [PAYLOAD_W-1:0] payload,
  output logic                 drop
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic sync_prev, sclk_prev;
  logic active, done;
  logic [CNT_W-1:0] cnt;
  logic [PAYLOAD_W-2:0] shreg;
  logic [PAYLOAD_W-1:0] nxt;
  logic sync_rise, sync_fall, sclk_fall;

  assign sync_rise = sync_lvl & ~sync_prev;
  assign sync_fall = ~sync_lvl & sync_prev;
  assign sclk_fall = ~sclk_lvl & sclk_prev;
  assign nxt       = {shreg, din_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_prev <= 1'b1;
      sclk_prev <= 1'b1;
      active    <= 1'b0;
      done      <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      commit    <= 1'b0;
      drop      <= 1'b0;
      payload   <= '0;
    end else begin
      sync_prev <= sync_lvl;
      sclk_prev <= sclk_lvl;
      commit    <= 1'b0;
      drop      <= 1'b0;
      if (sync_rise) begin
        if (active && !done) drop <= 1'b1;
        active <= 1'b0;
        done   <= 1'b0;
        cnt    <= '0;
        shreg  <= '0;
      end else if (sync_fall) begin
        active <= 1'b1;
        done   <= 1'b0;
        cnt    <= '0;
        shreg  <= '0;
      end else if (sclk_fall && active && !done) begin
        shreg <= nxt[PAYLOAD_W-2:0];
        if (cnt == LAST) begin
          done    <= 1'b1;
          commit  <= 1'b1;
          payload <= nxt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  a_r7_done_blocks_commit: assert property (@(posedge clk) disable iff (rst)
    done && !sync_fall |=> !commit);
  a_r6_drop_not_commit: assert property (@(posedge clk) disable iff (rst)
    !(drop && commit));
endmodule

// File: rtl/sdac_commit_regs.sv
module sdac_commit_regs
  import sdac_pkg::*;
#(
  parameter int unsigned CODE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     commit,
  input  logic [CODE_W+MODE_W-1:0] payload,
  input  logic                     drop,
  output logic [CODE_W-1:0]        dac_code,
  output logic [MODE_W-1:0]        pd_mode,
  output logic                     update,
  output logic                     abort
);
  pwr_mode_t new_mode;
  assign new_mode = pwr_mode_t'(payload[CODE_W +: MODE_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code <= '0;
      pd_mode  <= PM_NORMAL;
      update   <= 1'b0;
      abort    <= 1'b0;
    end else begin
      update <= commit;
      abort  <= drop;
      if (commit) begin
        pd_mode <= new_mode;
        if (new_mode == PM_NORMAL) dac_code <= payload[CODE_W-1:0];
      end
    end
  end

  a_r5_update_single: assert property (@(posedge clk) disable iff (rst)
    update |=> !update);
  a_r6_abort_holds_state: assert property (@(posedge clk) disable iff (rst)
    abort |-> ($stable(dac_code) && $stable(pd_mode) && !update));
  a_r6_abort_single: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort);
  a_r8_pd_keeps_code: assert property (@(posedge clk) disable iff (rst)
    update && (pd_mode != PM_NORMAL) |-> $stable(dac_code));
  a_r2_code_moves_on_update: assert property (@(posedge clk) disable iff (rst)
    !update |-> $stable(dac_code) && $stable(pd_mode));
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
#(
  parameter int unsigned FRAME_BITS  = 24,
  parameter int unsigned CODE_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [CODE_W-1:0] dac_code,
  output logic [1:0]        pd_mode,
  output logic              update,
  output logic              abort
);
  localparam int unsigned PAYLOAD_W = CODE_W + MODE_W;

  logic [2:0] raw_in, sync_q;
  logic commit, drop;
  logic [PAYLOAD_W-1:0] payload;

  assign raw_in = {sync_n, sclk, sdin};

  sdac_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_q)
  );

  sdac_shift_ctrl #(.FRAME_BITS(FRAME_BITS), .PAYLOAD_W(PAYLOAD_W)) u_shift (
    .clk(clk), .rst(rst),
    .sync_lvl(sync_q[2]), .sclk_lvl(sync_q[1]), .din_lvl(sync_q[0]),
    .commit(commit), .payload(payload), .drop(drop)
  );

  sdac_commit_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .commit(commit), .payload(payload), .drop(drop),
    .dac_code(dac_code), .pd_mode(pd_mode), .update(update), .abort(abort)
  );

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (dac_code == '0 && pd_mode == 2'b00 && !update && !abort));
endmodule

// File: tb/test_sdac_frame_rx.sv
module test_sdac_frame_rx;
  logic clk = 1'b0, rst = 1'b1;
  logic sync_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
  logic [15:0] dac_code;
  logic [1:0] pd_mode;
  logic update, abort;
  int n_chk = 0, n_err = 0, upd_cnt = 0, ab_cnt = 0;

  always #4 clk = ~clk;

  sdac_frame_rx i_sdac_frame_rx (
    .clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .dac_code(dac_code), .pd_mode(pd_mode), .update(update), .abort(abort)
  );

  always @(negedge clk) if (!rst) begin
    if (update) upd_cnt++;
    if (abort) ab_cnt++;
  end

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bits(logic [23:0] w, int n);
    for (int i = 0; i < n; i++) begin
      sdin = w[23 - (i % 24)];
      wclk(4); sclk = 1'b0;
      wclk(4); sclk = 1'b1;
    end
  endtask

  task automatic frame(logic [23:0] w, int n);
    sync_n = 1'b0; wclk(6);
    send_bits(w, n);
    wclk(4); sync_n = 1'b1; wclk(10);
  endtask

  task automatic t_reset();
    chk("R1 code", dac_code, 0); chk("R1 mode", pd_mode, 0);
    chk("R1 update", update, 0); chk("R1 abort", abort, 0);
  endtask

  task automatic t_basic();
    int u0 = upd_cnt;
    frame({6'b0, 2'b00, 16'h1234}, 24);
    chk("R2 code", dac_code, 16'h1234); chk("R4 mode normal", pd_mode, 0);
    chk("R5 one update", upd_cnt - u0, 1); chk("R7 no abort on late rise", ab_cnt, 0);
  endtask

  task automatic t_header();
    frame({6'b101101, 2'b00, 16'hBEEF}, 24);
    chk("R3 header ignored code", dac_code, 16'hBEEF); chk("R3 header ignored mode", pd_mode, 0);
  endtask

  task automatic t_abort();
    int u0 = upd_cnt, a0 = ab_cnt;
    frame({6'b0, 2'b11, 16'h5555}, 10);
    chk("R6 code held", dac_code, 16'hBEEF); chk("R6 mode held", pd_mode, 0);
    chk("R6 no update", upd_cnt - u0, 0); chk("R6 one abort", ab_cnt - a0, 1);
  endtask

  task automatic t_restart();
    frame({6'b0, 2'b00, 16'hA5C3}, 24);
    chk("R9 restart code", dac_code, 16'hA5C3);
  endtask

  task automatic t_extra();
    int u0 = upd_cnt, a0 = ab_cnt;
    sync_n = 1'b0; wclk(6);
    send_bits({6'b0, 2'b00, 16'h0F0F}, 24);
    send_bits({6'b0, 2'b10, 16'h2222}, 24);
    wclk(4); sync_n = 1'b1; wclk(10);
    chk("R7 code kept", dac_code, 16'h0F0F); chk("R7 mode kept", pd_mode, 0);
    chk("R7 single update", upd_cnt - u0, 1); chk("R7 no abort", ab_cnt - a0, 0);
  endtask

  task automatic t_modes();
    for (int m = 1; m < 4; m++) begin
      frame({6'b0, m[1:0], 16'hFFFF}, 24);
      chk("R4 mode code", pd_mode, m);
      chk("R8 power-down keeps code", dac_code, 16'h0F0F);
    end
    frame({6'b0, 2'b00, 16'h8000}, 24);
    chk("R8 normal reloads code", dac_code, 16'h8000); chk("R4 back to normal", pd_mode, 0);
  endtask

  task automatic t_reset_again();
    rst = 1'b1; wclk(3);
    t_reset();
    rst = 1'b0; wclk(5);
    t_reset();
  endtask

  initial begin
    fork
      begin
        wclk(5); t_reset(); rst = 1'b0; wclk(5); t_reset();
        t_basic(); t_header(); t_abort(); t_restart();
        t_extra(); t_modes(); t_reset_again();
      end
      begin
        wclk(150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule